// File: doc/BRIEF.md
# Burst-Capable Word Memory Slave

This block is a single-port memory that answers a 32-bit, word-addressed Wishbone bus. It serves classic single accesses and registered-feedback bursts. The master announces the kind of each beat through a three-bit cycle-type code and, for incrementing bursts, the wrap length through a two-bit burst-extension code. While a burst continues, the slave works out the next word address one cycle ahead. It starts the memory read for that word before the master presents it, so every beat after the first is acknowledged in the very next clock.

Writes use four byte-lane enables. Reads return a whole word; the lane enables do not affect read data. The memory depth is set by the word-address width parameter. Back-pressure comes only from the master. A low STB stalls the transfer: the slave gives no acknowledge while STB is low, keeps no partial beat, and resumes with one wait state once STB returns. An acknowledge is never given while CYC or STB is low.

Top module: `wbr_burst_ram`

## Requirements
- R1: A word written at a word address reads back unchanged from that address. The data bus is 32 bits and addresses count words.
- R2: A classic cycle (cycle type 000) is acknowledged for exactly one clock, one clock after CYC and STB are first seen. In the clock after that acknowledge, ack_o is low.
- R3: During a write, byte lane i (data bits 8i+7 down to 8i) of the addressed word changes only when sel_i bit i is 1. The other lanes keep their old contents.
- R4: An incrementing burst (cycle type 010) with extension 00 advances one word per beat. It has one wait state before the first beat and none between later beats.
- R5: Extension 01 gives a 4-beat wrap in which only address bits 1:0 count and the upper bits stay fixed. A burst starting at word 1 visits words 1, 2, 3 and then 0.
- R6: A constant-address burst (cycle type 001) keeps every beat at the same word and acknowledges each beat after the first in the next clock.
- R7: A beat with cycle type 111 is the last beat of a burst. In the clock after its acknowledge, ack_o is low and the slave behaves as for classic cycles.
- R8: While STB is low in the middle of a burst, ack_o stays low. After STB rises again, exactly one wait state comes before the next beat, and that beat returns the data of the word being presented.
- R9: While rst_n is low, ack_o and dat_o are 0.
- R10: Extensions 10 and 11 wrap the incrementing address within aligned blocks of 8 and 16 words (address bits 2:0 and 3:0 count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe: the current beat is valid |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Word address |
| sel_i | input | 4 | Byte-lane write enables |
| dat_i | input | 32 | Write data |
| cti_i | input | 3 | Cycle type: 000 classic, 001 constant, 010 incrementing, 111 last beat |
| bte_i | input | 2 | Burst extension: 00 linear, 01 wrap 4, 10 wrap 8, 11 wrap 16 |
| ack_o | output | 1 | Beat acknowledge |
| dat_o | output | 32 | Read data, valid while ack_o is high on a read |

## Verification
The delicate cycle is the one in which STB rises again after a mid-burst stall. That cycle carries both the held beat address and a continuing burst type, so address prediction and stall recovery meet there. The design must read the held word and not its successor. The bench provokes this by dropping STB for two clocks after a beat of a wrap-4 read burst and after a beat of a linear read burst. It then judges that acknowledge stays low during the stall, that exactly one wait state follows, and that the returned word equals the value it computed for the held address.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  // Cycle-type codes carried on cti_i
  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_CONST   = 3'b001;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_LAST    = 3'b111;

  // Burst-extension codes carried on bte_i
  localparam logic [1:0] BTE_LINEAR  = 2'b00;
  localparam logic [1:0] BTE_WRAP4   = 2'b01;
  localparam logic [1:0] BTE_WRAP8   = 2'b10;
  localparam logic [1:0] BTE_WRAP16  = 2'b11;

  // True when the beat announces that another beat follows
  function automatic logic burst_continues(input logic [2:0] cti);
    return (cti == CTI_INCR) || (cti == CTI_CONST);
  endfunction
endpackage

// File: rtl/wbr_addr_gen.sv
module wbr_addr_gen
  import wbr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] cur_adr_i,
  input  logic [2:0]        cti_i,
  input  logic [1:0]        bte_i,
  output logic [ADDR_W-1:0] nxt_adr_o
);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] M4   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] M8   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] M16  = ADDR_W'(15);

  logic [ADDR_W-1:0] count_mask;
  logic [ADDR_W-1:0] bumped;

  // Bits inside the mask count; bits outside stay fixed
  always_comb begin
    unique case (bte_i)
      BTE_WRAP4:  count_mask = M4;
      BTE_WRAP8:  count_mask = M8;
      BTE_WRAP16: count_mask = M16;
      default:    count_mask = '1;
    endcase
  end

  assign bumped = cur_adr_i + ONE;

  always_comb begin
    if (cti_i == CTI_INCR)
      nxt_adr_o = (cur_adr_i & ~count_mask) | (bumped & count_mask);
    else
      nxt_adr_o = cur_adr_i;
  end
endmodule

// File: rtl/wbr_ack_ctrl.sv
module wbr_ack_ctrl
  import wbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_i,
  input  logic       stb_i,
  input  logic [2:0] cti_i,
  output logic       ack_o,
  output logic       advance_o
);
  logic ack_q;
  logic req;
  logic cont;

  assign req       = cyc_i & stb_i;
  assign cont      = burst_continues(cti_i);
  assign ack_o     = ack_q & req;
  // A completing beat that promises a successor moves the read address on
  assign advance_o = ack_o & cont;

  // Arm the acknowledge for a fresh request, or keep it armed while a
  // completing beat says the burst goes on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req & (~ack_o | cont);
  end
endmodule

// File: rtl/wbr_lane_ram.sv
module wbr_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_adr_i,
  input  logic [LANES-1:0]     sel_i,
  input  logic [8*LANES-1:0]   wr_dat_i,
  input  logic [ADDR_W-1:0]    rd_adr_i,
  output logic [8*LANES-1:0]   rd_dat_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en_i && sel_i[g]) mem[wr_adr_i] <= wr_dat_i[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 8'h00;
      else        rd_q <= mem[rd_adr_i];
    end

    assign rd_dat_o[8*g +: 8] = rd_q;
  end
endmodule

// File: rtl/wbr_burst_ram.sv
module wbr_burst_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cyc_i,
  input  logic                  stb_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     adr_i,
  input  logic [DATA_W/8-1:0]   sel_i,
  input  logic [DATA_W-1:0]     dat_i,
  input  logic [2:0]            cti_i,
  input  logic [1:0]            bte_i,
  output logic                  ack_o,
  output logic [DATA_W-1:0]     dat_o
);
  localparam int LANES = DATA_W / 8;

  logic              ack_w;
  logic              advance_w;
  logic [ADDR_W-1:0] nxt_adr;
  logic [ADDR_W-1:0] rd_adr;

  wbr_ack_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_i     (cyc_i),
    .stb_i     (stb_i),
    .cti_i     (cti_i),
    .ack_o     (ack_w),
    .advance_o (advance_w)
  );

  wbr_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .cur_adr_i (adr_i),
    .cti_i     (cti_i),
    .bte_i     (bte_i),
    .nxt_adr_o (nxt_adr)
  );

  // Read ahead: the beat completing now already names its successor
  assign rd_adr = advance_w ? nxt_adr : adr_i;

  wbr_lane_ram #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (ack_w & we_i),
    .wr_adr_i (adr_i),
    .sel_i    (sel_i),
    .wr_dat_i (dat_i),
    .rd_adr_i (rd_adr),
    .rd_dat_o (dat_o)
  );

  assign ack_o = ack_w;
endmodule

// File: rtl/wbr_sva.sv
module wbr_sva
  import wbr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_i,
  input logic       stb_i,
  input logic [2:0] cti_i,
  input logic       ack_o
);
  // R2: a pending request is answered in the next clock
  a_r2_first_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && stb_i && !ack_o) |=> (ack_o || !(cyc_i && stb_i)));

  // R2: a classic acknowledge lasts one clock
  a_r2_classic_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && cti_i == CTI_CLASSIC) |=> !ack_o);

  // R4 / R6: continuing bursts run without wait states
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && (cti_i == CTI_INCR || cti_i == CTI_CONST)) |=> (ack_o || !(cyc_i && stb_i)));

  // R7: the last beat releases the acknowledge
  a_r7_last_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && cti_i == CTI_LAST) |=> !ack_o);

  // R8: a stalled clock is followed by a wait state
  a_r8_stall_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && !stb_i) |=> !ack_o);
endmodule

bind wbr_burst_ram wbr_sva u_sva (
  .clk   (clk),
  .rst_n (rst_n),
  .cyc_i (cyc_i),
  .stb_i (stb_i),
  .cti_i (cti_i),
  .ack_o (ack_o)
);

// File: tb/wbr_burst_ram_tb_top.sv
module wbr_burst_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] adr_i = '0;
  logic [3:0]        sel_i = 4'h0;
  logic [31:0]       dat_i = '0;
  logic [2:0]        cti_i = 3'b000;
  logic [1:0]        bte_i = 2'b00;
  logic              ack_o;
  logic [31:0]       dat_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] ref_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  wbr_burst_ram #(.ADDR_W(ADDR_W), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i), .cti_i(cti_i), .bte_i(bte_i),
    .ack_o(ack_o), .dat_o(dat_o)
  );

  function automatic logic [31:0] pat(input int k, input int seed);
    return 32'(k) * 32'h9E3779B1 + 32'(seed) * 32'h01000193 + 32'h5A5A0000;
  endfunction

  function automatic int next_adr(input int a, input logic [2:0] kind, input logic [1:0] bte);
    int m;
    if (kind == 3'b001) return a;
    m = (bte == 2'b00) ? DEPTH - 1 : (bte == 2'b01) ? 3 : (bte == 2'b10) ? 7 : 15;
    return ((a & ~m) | ((a + 1) & m)) & (DEPTH - 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Master model; entered and left at a falling edge with the bus idle
  task automatic run_burst(input int start, input int n, input logic [2:0] kind,
                           input logic [1:0] bte, input bit wr, input logic [3:0] sel,
                           input int seed, input int stall_after, input string req);
    int a = start;
    for (int k = 0; k < n; k++) begin
      int waits = 0;
      int expw;
      logic [31:0] d = pat(k, seed);
      cyc_i = 1'b1; stb_i = 1'b1; we_i = wr; adr_i = ADDR_W'(a);
      cti_i = (kind == 3'b000) ? 3'b000 : ((k == n - 1) ? 3'b111 : kind);
      bte_i = bte; sel_i = sel; dat_i = d;
      #1;
      while (!ack_o) begin
        waits++;
        @(negedge clk); #1;
      end
      expw = (k == 0 || k == stall_after + 1) ? 1 : 0;
      check(waits == expw, req, "wait states", 32'(waits), 32'(expw));
      if (wr) begin
        for (int l = 0; l < 4; l++)
          if (sel[l]) ref_mem[a][8*l +: 8] = d[8*l +: 8];
      end else begin
        check(dat_o == ref_mem[a], req, "read data", dat_o, ref_mem[a]);
      end
      @(negedge clk);
      if (k == stall_after) begin
        stb_i = 1'b0; #1;
        check(ack_o == 1'b0, "R8", "ack during stall", 32'(ack_o), 32'h0);
        @(negedge clk); #1;
        check(ack_o == 1'b0, "R8", "ack during stall", 32'(ack_o), 32'h0);
        @(negedge clk);
      end
      a = next_adr(a, kind, bte);
    end
    #1;
    check(ack_o == 1'b0, (kind == 3'b000) ? "R2" : "R7", "ack after final beat",
          32'(ack_o), 32'h0);
    cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic classic_rd(input int a, input string req);
    run_burst(a, 1, 3'b000, 2'b00, 1'b0, 4'hF, 0, -1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(ack_o == 1'b0, "R9", "ack in reset", 32'(ack_o), 32'h0);
    check(dat_o == 32'h0, "R9", "data in reset", dat_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: fill and read back with classic cycles
    for (int a = 0; a < DEPTH; a++)
      run_burst(a, 1, 3'b000, 2'b00, 1'b1, 4'hF, 100 + a, -1, "R1");
    for (int a = 0; a < DEPTH; a++) classic_rd(a, "R1");

    // R3: every lane-enable pattern
    for (int s = 0; s < 16; s++) begin
      run_burst(s, 1, 3'b000, 2'b00, 1'b1, 4'(s), 300 + s, -1, "R3");
      classic_rd(s, "R3");
    end

    // R4: linear incrementing burst over the whole memory
    run_burst(0, DEPTH, 3'b010, 2'b00, 1'b1, 4'hF, 7, -1, "R4");
    run_burst(0, DEPTH, 3'b010, 2'b00, 1'b0, 4'hF, 0, -1, "R4");

    // R5: wrap-4 from word 1 lands its fourth beat on word 0
    run_burst(1, 4, 3'b010, 2'b01, 1'b1, 4'hF, 55, -1, "R5");
    classic_rd(0, "R5");
    check(ref_mem[0] == pat(3, 55), "R5", "fourth beat at word 0", ref_mem[0], pat(3, 55));

    // R5 / R10: every start offset of each wrap size
    for (int s = 0; s < 4; s++) begin
      run_burst(20 + s, 4, 3'b010, 2'b01, 1'b1, 4'hF, 400 + s, -1, "R5");
      run_burst(20 + s, 4, 3'b010, 2'b01, 1'b0, 4'hF, 0, -1, "R5");
      for (int w = 20; w < 24; w++) classic_rd(w, "R5");
    end
    for (int s = 0; s < 8; s++) begin
      run_burst(32 + s, 8, 3'b010, 2'b10, 1'b1, 4'hF, 500 + s, -1, "R10");
      run_burst(32 + s, 8, 3'b010, 2'b10, 1'b0, 4'hF, 0, -1, "R10");
    end
    for (int w = 28; w < 44; w++) classic_rd(w, "R10");
    for (int s = 0; s < 16; s++) begin
      run_burst(48 + s, 16, 3'b010, 2'b11, 1'b1, 4'hF, 600 + s, -1, "R10");
      run_burst(48 + s, 16, 3'b010, 2'b11, 1'b0, 4'hF, 0, -1, "R10");
    end
    for (int w = 44; w < DEPTH; w++) classic_rd(w, "R10");

    // R6: constant-address bursts, with a lane mask on the write
    run_burst(5, 4, 3'b001, 2'b00, 1'b1, 4'hF, 700, -1, "R6");
    run_burst(5, 4, 3'b001, 2'b00, 1'b0, 4'hF, 0, -1, "R6");
    run_burst(6, 3, 3'b001, 2'b00, 1'b1, 4'h5, 710, -1, "R6");
    classic_rd(6, "R6");
    classic_rd(7, "R6");

    // R8: stalls in the middle of read bursts
    run_burst(21, 4, 3'b010, 2'b01, 1'b0, 4'hF, 0, 1, "R8");
    run_burst(8, 10, 3'b010, 2'b00, 1'b0, 4'hF, 0, 4, "R8");
    run_burst(9, 4, 3'b010, 2'b00, 1'b1, 4'hF, 800, 0, "R8");
    for (int w = 9; w < 13; w++) classic_rd(w, "R8");

    summary();
  end
endmodule